// File: doc/BRIEF.md
# Scan-Com Register Access Bridge

This block sits between a 64-bit memory-mapped access port and an internal register bus on which each target is selected by a register number, not a byte address. Each upstream access is an aligned 8-byte word, carried in big-endian byte order: the byte at the lowest address is the most significant byte of the word. The block passes the word through unchanged. The byte address is first masked to the window size. A mode input then picks one of two schemes that turn it into a register number. The linear scheme shifts the address right by three. The interleaved scheme keeps address bits 6..3 as the low nibble of the register number and takes the upper bits from address bit 8 upward, so address bit 7 is dropped.

A few register numbers are answered locally. The identification register returns a build-time constant. A group of fault, fault-mask, log, error and receive-status registers reads as zero and discards writes. All other accesses go to the downstream bus at byte address register-number times eight, over a valid/ready request channel and a response channel that carries an error flag. Only one access is in flight at a time. The upstream requester keeps its request high until it sees the one-cycle acknowledge. Each completed access ORs a done bit, and on failure also a fail bit, into a two-bit sticky status register. Software clears that register by writing zeros to the bits it wants cleared.

Top module: `scom_mmio_bridge`

## Requirements
- R1: With `mode_lin`=1 the register number is (address masked to WIN_W bits) >> 3, and a forwarded access appears on `dn_addr` as register number << 3; address bits at or above WIN_W have no effect.
- R2: With `mode_lin`=0 the register number is ((m >> 4) with its low 4 bits cleared) OR ((m >> 3) & 0xF), where m is the masked address, and a forwarded access uses `dn_addr` = register number << 3.
- R3: A read of register number 0xF000F returns CHIP_ID with `up_fail`=0 and is not forwarded; a write to it is acknowledged, not forwarded, and leaves the read value unchanged.
- R4: Reads of register numbers 0x1010C00, 0x1010C03, 0x0090012, 0x0090013, 0x0090018, 0x2020007, 0x2020009 and 0x202000F return zero locally without being forwarded.
- R5: Writes to register numbers 0x1010C00 to 0x1010C05, 0x0090012, 0x0090013, 0x0090018, 0x2020007, 0x2020009 and 0x202000F are acknowledged and discarded without being forwarded.
- R6: Any other aligned access is forwarded once, with its write flag and write data, and holds `dn_valid` and `dn_addr` steady until `dn_ready`; a successful read returns `dn_rdata` on `up_rdata`.
- R7: A downstream error response completes the access with `up_fail`=1, sets status bits fail (bit 1) and done (bit 0), and a failed read returns zero.
- R8: Every access that succeeds, local or forwarded, sets status bit 0 (done) and leaves bit 1 (fail) unchanged.
- R9: Status bits are sticky; a cycle with `st_clr_we`=1 clears each bit whose `st_clr_keep` bit is 0; a completion in the same cycle still sets its bits.
- R10: An access whose address bits 2..0 are not zero is not forwarded and completes with `up_fail`=1, read data zero, and status done and fail set.
- R11: After reset `up_ack`, `dn_valid` and both status bits are 0.
- R12: `up_ack` is a one-cycle pulse and, for a forwarded access, comes only after the downstream response; no new access starts while one is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_lin | input | 1 | 1: linear translation, 0: interleaved translation |
| up_req | input | 1 | Upstream access request, held until acknowledged |
| up_we | input | 1 | Upstream write when 1, read when 0 |
| up_addr | input | AW | Upstream byte address |
| up_wdata | input | 64 | Upstream write word |
| up_ack | output | 1 | One-cycle completion pulse |
| up_rdata | output | 64 | Read word, valid with up_ack |
| up_fail | output | 1 | Access failed, valid with up_ack |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_we | output | 1 | Downstream write flag |
| dn_addr | output | WIN_W | Downstream byte address (register number << 3) |
| dn_wdata | output | 64 | Downstream write word |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_err | input | 1 | Downstream response is an error |
| dn_rdata | input | 64 | Downstream read word |
| st_clr_we | input | 1 | Status clear strobe |
| st_clr_keep | input | 2 | Bits written 0 are cleared |
| st_bits | output | 2 | Sticky status: bit 1 fail, bit 0 done |

## Verification
On every cycle the assertions check that an acknowledge pulse always finds the done bit set, that a failed completion carries zero data, and that the downstream request holds until accepted. They also check that the acknowledge never overlaps a pending downstream request and that status bits stay set unless a clear strobe is present. The two translation formulas, the intercept table contents and the fact that intercepted numbers never reach the downstream bus can only be shown by the bench. It sweeps both modes over every table entry and a spread of forwarded addresses, comparing the results with arithmetic it computes itself.

// File: rtl/scom_bridge_pkg.sv
// Package: shared types and the local intercept table for the bridge.
// Assumes register numbers are 32 bits wide.
package scom_bridge_pkg;

    localparam int DATA_W = 64;
    localparam int REGN_W = 32;
    localparam logic [REGN_W-1:0] IDENT_REGN = 32'h000F_000F;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } brg_state_t;

    // Register numbers whose reads are answered with zero.
    function automatic logic reads_as_zero(input logic [REGN_W-1:0] n);
        case (n)
            32'h0101_0C00, 32'h0101_0C03,
            32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
            32'h0202_0007, 32'h0202_0009, 32'h0202_000F: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Register numbers whose writes are acknowledged and dropped.
    function automatic logic write_dropped(input logic [REGN_W-1:0] n);
        case (n)
            IDENT_REGN,
            32'h0101_0C00, 32'h0101_0C01, 32'h0101_0C02,
            32'h0101_0C03, 32'h0101_0C04, 32'h0101_0C05,
            32'h0009_0012, 32'h0009_0013, 32'h0009_0018,
            32'h0202_0007, 32'h0202_0009, 32'h0202_000F: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/scom_addr_xlate.sv
// Address translator: masks the byte address to the window and forms the
// register number with the linear or the interleaved scheme.
// Assumes AW > WIN_W and WIN_W > 8.
module scom_addr_xlate #(
    parameter int AW    = 40,
    parameter int WIN_W = 35
) (
    input  logic              mode_lin,
    input  logic [AW-1:0]     addr,
    output logic [WIN_W-4:0]  regn,
    output logic              misal
);
    localparam int RN_W = WIN_W - 3;

    logic [WIN_W-1:0] win_addr;
    logic             unused_hi;

    assign win_addr  = addr[WIN_W-1:0];
    assign unused_hi = ^addr[AW-1:WIN_W];

    // Pick the translation scheme selected by the mode input.
    always_comb begin
        if (mode_lin) begin
            regn = win_addr[WIN_W-1:3];
        end else begin
            regn = {1'b0, win_addr[WIN_W-1:8], win_addr[6:3]};
        end
        misal = |win_addr[2:0];
    end

    initial begin
        if (RN_W < 8) $error("window too small");
    end
endmodule

// File: rtl/scom_intercept.sv
// Local intercept decoder: says whether a register number is answered
// locally for reads or writes and supplies the local read value.
// Assumes register numbers narrower than 32 bits are zero-extended.
module scom_intercept #(
    parameter int          RN_W    = 32,
    parameter logic [63:0] CHIP_ID = 64'h220E_A049_0000_0000
) (
    input  logic [RN_W-1:0] regn,
    output logic            rd_hit,
    output logic            wr_hit,
    output logic [63:0]     rd_val
);
    import scom_bridge_pkg::*;

    logic [REGN_W-1:0] rn32;

    // Widen or narrow the register number to the table width.
    generate
        if (RN_W >= REGN_W) begin : g_trunc
            assign rn32 = regn[REGN_W-1:0];
            if (RN_W > REGN_W) begin : g_unused
                logic unused_rn;
                assign unused_rn = ^regn[RN_W-1:REGN_W-((RN_W>REGN_W)?0:1)];
            end
        end else begin : g_ext
            assign rn32 = {{(REGN_W-RN_W){1'b0}}, regn};
        end
    endgenerate

    // Decode the table and the local read value.
    always_comb begin
        wr_hit = write_dropped(rn32);
        if (rn32 == IDENT_REGN) begin
            rd_hit = 1'b1;
            rd_val = CHIP_ID;
        end else begin
            rd_hit = reads_as_zero(rn32);
            rd_val = '0;
        end
    end
endmodule

// File: rtl/scom_status_reg.sv
// Sticky status register: completions OR in done/fail; software clears
// bits by writing zeros. A completion in a clear cycle wins.
module scom_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       post_en,
    input  logic       post_fail,
    input  logic       clr_we,
    input  logic [1:0] clr_keep,
    output logic [1:0] bits_q
);
    logic [1:0] kept;

    // Apply the software clear mask before posting.
    always_comb begin
        kept = clr_we ? (bits_q & clr_keep) : bits_q;
    end

    // Hold the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= 2'b00;
        end else begin
            bits_q <= kept | (post_en ? {post_fail, 1'b1} : 2'b00);
        end
    end

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bits_q[0]) && !$past(clr_we)) |-> bits_q[0]); // R9
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bits_q[1]) && !$past(clr_we)) |-> bits_q[1]); // R9
endmodule

// File: rtl/scom_mmio_bridge.sv
// Top: accepts one upstream 8-byte access at a time, translates it,
// answers intercepted register numbers locally, forwards the rest over a
// valid/ready bus and posts sticky done/fail status on completion.
// Assumes the requester holds up_req until up_ack and that a downstream
// response comes at least one cycle after its request is accepted.
module scom_mmio_bridge #(
    parameter int          AW      = 40,
    parameter int          WIN_W   = 35,
    parameter logic [63:0] CHIP_ID = 64'h220E_A049_0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_lin,
    input  logic             up_req,
    input  logic             up_we,
    input  logic [AW-1:0]    up_addr,
    input  logic [63:0]      up_wdata,
    output logic             up_ack,
    output logic [63:0]      up_rdata,
    output logic             up_fail,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic             dn_we,
    output logic [WIN_W-1:0] dn_addr,
    output logic [63:0]      dn_wdata,
    input  logic             dn_rsp_valid,
    input  logic             dn_rsp_err,
    input  logic [63:0]      dn_rdata,
    input  logic             st_clr_we,
    input  logic [1:0]       st_clr_keep,
    output logic [1:0]       st_bits
);
    import scom_bridge_pkg::*;

    localparam int RN_W = WIN_W - 3;

    brg_state_t       state_q;
    logic [RN_W-1:0]  regn;
    logic             misal;
    logic             rd_hit;
    logic             wr_hit;
    logic [63:0]      loc_val;
    logic             fin_now;
    logic             fin_fail;
    logic             local_hit;
    logic             req_we_q;

    scom_addr_xlate #(.AW(AW), .WIN_W(WIN_W)) u_xlate (
        .mode_lin (mode_lin),
        .addr     (up_addr),
        .regn     (regn),
        .misal    (misal)
    );

    scom_intercept #(.RN_W(RN_W), .CHIP_ID(CHIP_ID)) u_icpt (
        .regn   (regn),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit),
        .rd_val (loc_val)
    );

    scom_status_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .post_en   (fin_now),
        .post_fail (fin_fail),
        .clr_we    (st_clr_we),
        .clr_keep  (st_clr_keep),
        .bits_q    (st_bits)
    );

    assign local_hit = up_we ? wr_hit : rd_hit;
    assign dn_valid  = (state_q == ST_ISSUE);

    // Decide whether the access completes in this cycle and how.
    always_comb begin
        fin_now  = 1'b0;
        fin_fail = 1'b0;
        case (state_q)
            ST_IDLE: if (up_req && (misal || local_hit)) begin
                fin_now  = 1'b1;
                fin_fail = misal;
            end
            ST_WAIT: if (dn_rsp_valid) begin
                fin_now  = 1'b1;
                fin_fail = dn_rsp_err;
            end
            default: ;
        endcase
    end

    // Sequence one access: accept, forward if needed, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            up_ack   <= 1'b0;
            up_rdata <= '0;
            up_fail  <= 1'b0;
            dn_we    <= 1'b0;
            dn_addr  <= '0;
            dn_wdata <= '0;
            req_we_q <= 1'b0;
        end else begin
            up_ack <= 1'b0;
            case (state_q)
                ST_IDLE: if (up_req) begin
                    req_we_q <= up_we;
                    if (fin_now) begin
                        state_q  <= ST_RESP;
                        up_ack   <= 1'b1;
                        up_fail  <= fin_fail;
                        up_rdata <= (misal || up_we) ? '0 : loc_val;
                    end else begin
                        state_q  <= ST_ISSUE;
                        dn_we    <= up_we;
                        dn_addr  <= {regn, 3'b000};
                        dn_wdata <= up_wdata;
                    end
                end
                ST_ISSUE: if (dn_ready) state_q <= ST_WAIT;
                ST_WAIT: if (dn_rsp_valid) begin
                    state_q  <= ST_RESP;
                    up_ack   <= 1'b1;
                    up_fail  <= dn_rsp_err;
                    up_rdata <= (dn_rsp_err || req_we_q) ? '0 : dn_rdata;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |-> st_bits[0]); // R8
    AST_FAIL_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (up_ack && up_fail) |-> (up_rdata == '0)); // R7
    AST_FAIL_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
        (up_ack && up_fail) |-> st_bits[1]); // R7
    AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr))); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |=> !up_ack); // R12
    AST_NO_ACK_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !up_ack); // R12
endmodule

// File: tb/test_scom_mmio_bridge.sv
// Bench: sweeps both translation modes over the intercept table and a
// spread of forwarded addresses, with a responder model downstream.
module test_scom_mmio_bridge;
    localparam int          CLK_P   = 10;
    localparam int          AW      = 40;
    localparam int          WIN_W   = 35;
    localparam logic [63:0] CHIP_ID = 64'h1234_5678_9ABC_DEF0;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_lin = 1'b1;
    logic             up_req = 1'b0;
    logic             up_we = 1'b0;
    logic [AW-1:0]    up_addr = '0;
    logic [63:0]      up_wdata = '0;
    logic             up_ack;
    logic [63:0]      up_rdata;
    logic             up_fail;
    logic             dn_valid;
    logic             dn_ready = 1'b0;
    logic             dn_we;
    logic [WIN_W-1:0] dn_addr;
    logic [63:0]      dn_wdata;
    logic             dn_rsp_valid = 1'b0;
    logic             dn_rsp_err = 1'b0;
    logic [63:0]      dn_rdata = '0;
    logic             st_clr_we = 1'b0;
    logic [1:0]       st_clr_keep = 2'b11;
    logic [1:0]       st_bits;

    int checks = 0;
    int errors = 0;

    // responder state
    int               fwd_cnt = 0;
    int               stall_n = 0;
    int               lat_n = 0;
    logic             err_next = 1'b0;
    logic             rsp_sent = 1'b0;
    logic [WIN_W-1:0] cap_addr = '0;
    logic             cap_we = 1'b0;
    logic [63:0]      cap_wdata = '0;
    logic [1:0]       exp_st = 2'b00;

    scom_mmio_bridge #(.AW(AW), .WIN_W(WIN_W), .CHIP_ID(CHIP_ID)) i_scom_mmio_bridge (
        .clk, .rst_n, .mode_lin, .up_req, .up_we, .up_addr, .up_wdata,
        .up_ack, .up_rdata, .up_fail, .dn_valid, .dn_ready, .dn_we,
        .dn_addr, .dn_wdata, .dn_rsp_valid, .dn_rsp_err, .dn_rdata,
        .st_clr_we, .st_clr_keep, .st_bits
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [63:0] rsp_word(input logic [WIN_W-1:0] a);
        return 64'hA5C3_0000_0000_0000 ^ {29'b0, a} ^ ({29'b0, a} << 27);
    endfunction

    function automatic logic [31:0] regn_of(input logic lin, input logic [AW-1:0] a);
        logic [63:0] m;
        m = {24'b0, a} & ((64'd1 << WIN_W) - 1);
        if (lin) return 32'((m >> 3));
        return 32'((((m >> 4) & ~64'hF) | ((m >> 3) & 64'hF)));
    endfunction

    function automatic logic [AW-1:0] addr_of(input logic lin, input logic [31:0] n);
        if (lin) return AW'({8'b0, n} << 3);
        return AW'((({8'b0, n} >> 4) << 8) | ({8'b0, n & 32'hF} << 3));
    endfunction

    function automatic logic is_local(input logic we, input logic [31:0] n);
        logic [31:0] rz [8] = '{32'h1010C00, 32'h1010C03, 32'h0090012, 32'h0090013,
                                32'h0090018, 32'h2020007, 32'h2020009, 32'h202000F};
        if (n == 32'hF000F) return 1'b1;
        if (we && n >= 32'h1010C00 && n <= 32'h1010C05) return 1'b1;
        foreach (rz[k]) if (rz[k] == n) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Downstream responder: accepts after stall_n cycles, answers after lat_n.
    initial begin
        forever begin
            @(negedge clk);
            if (dn_valid) begin
                cap_addr  = dn_addr;
                cap_we    = dn_we;
                cap_wdata = dn_wdata;
                fwd_cnt++;
                repeat (stall_n) @(negedge clk);
                dn_ready = 1'b1;
                @(negedge clk);
                dn_ready = 1'b0;
                repeat (lat_n) @(negedge clk);
                dn_rdata     = rsp_word(cap_addr);
                dn_rsp_err   = err_next;
                dn_rsp_valid = 1'b1;
                rsp_sent     = 1'b1;
                @(negedge clk);
                dn_rsp_valid = 1'b0;
                dn_rsp_err   = 1'b0;
            end
        end
    end

    task automatic access(input logic lin, input logic we, input logic [AW-1:0] a,
                          input logic [63:0] wd, output logic [63:0] rd,
                          output logic fl, output logic early);
        int n;
        @(negedge clk);
        mode_lin = lin; up_we = we; up_addr = a; up_wdata = wd; up_req = 1'b1;
        rsp_sent = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!up_ack && n < 300);
        if (n >= 300) check(1'b0, "R12", "watchdog expired", 64'(n), 64'd0);
        early = !rsp_sent;
        rd = up_rdata;
        fl = up_fail;
        up_req = 1'b0;
        @(negedge clk);
        check(!up_ack, "R12", "ack one cycle", 64'(up_ack), 64'd0);
    endtask

    initial begin
        logic [63:0] rd;
        logic fl, early;
        int f0;
        logic [31:0] lst [14] = '{32'hF000F, 32'h1010C00, 32'h1010C01, 32'h1010C02,
                                  32'h1010C03, 32'h1010C04, 32'h1010C05, 32'h1010C00,
                                  32'h0090012, 32'h0090013, 32'h0090018, 32'h2020007,
                                  32'h2020009, 32'h202000F};

        repeat (3) @(negedge clk);
        // R11 reset state
        check(up_ack == 1'b0 && dn_valid == 1'b0, "R11", "ack/valid after reset",
              {62'b0, up_ack, dn_valid}, 64'd0);
        check(st_bits == 2'b00, "R11", "status after reset", 64'(st_bits), 64'd0);
        rst_n = 1'b1;

        // R3/R4/R5 intercept table in both modes, plus high-address masking (R1)
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 14; k++) begin
                logic [AW-1:0] a;
                logic [63:0] exp_rd;
                a = addr_of(m[0], lst[k]) | (40'h80_0000_0000 >> (k % 2));
                if (is_local(1'b0, lst[k])) begin
                    f0 = fwd_cnt;
                    access(m[0], 1'b0, a, 64'h0, rd, fl, early);
                    exp_rd = (lst[k] == 32'hF000F) ? CHIP_ID : 64'h0;
                    check(rd == exp_rd && !fl, (lst[k] == 32'hF000F) ? "R3" : "R4",
                          "local read value", rd, exp_rd);
                    check(fwd_cnt == f0, "R4", "local read not forwarded",
                          64'(fwd_cnt - f0), 64'd0);
                    exp_st = exp_st | 2'b01;
                    check(st_bits == exp_st, "R8", "done after local read",
                          64'(st_bits), 64'(exp_st));
                end
                f0 = fwd_cnt;
                access(m[0], 1'b1, a, 64'hDEAD_BEEF_0000_0000 + 64'(k), rd, fl, early);
                check(fwd_cnt == f0 && !fl, "R5", "write discarded locally",
                      64'(fwd_cnt - f0), 64'd0);
                exp_st = exp_st | 2'b01;
                check(st_bits == exp_st, "R8", "done after local write",
                      64'(st_bits), 64'(exp_st));
            end
        end
        // R3 identification value unchanged after a write
        access(1'b1, 1'b0, addr_of(1'b1, 32'hF000F), 64'h0, rd, fl, early);
        check(rd == CHIP_ID, "R3", "ident after write", rd, CHIP_ID);

        // R1/R2/R6/R7/R12 forwarded sweep
        for (int i = 0; i < 60; i++) begin
            logic [AW-1:0] a;
            logic [31:0] rn;
            logic lin, we, er;
            logic [WIN_W-1:0] exp_a;
            lin = i[0];
            we  = (i % 3) == 0;
            er  = (i % 7) == 5;
            a   = (AW'(i) * 40'h01_2345_6789 + AW'(i) * 8) & ~40'h7;
            rn  = regn_of(lin, a);
            if (is_local(we, rn)) continue;
            stall_n = i % 4; lat_n = i % 3; err_next = er;
            f0 = fwd_cnt;
            access(lin, we, a, {32'hC0DE_0000, 32'(i)}, rd, fl, early);
            exp_a = WIN_W'({32'b0, rn} << 3);
            check(fwd_cnt == f0 + 1, "R6", "forwarded once", 64'(fwd_cnt - f0), 64'd1);
            check(cap_addr == exp_a, lin ? "R1" : "R2", "downstream address",
                  64'(cap_addr), 64'(exp_a));
            check(cap_we == we, "R6", "write flag", 64'(cap_we), 64'(we));
            if (we) check(cap_wdata == {32'hC0DE_0000, 32'(i)}, "R6", "write data",
                          cap_wdata, {32'hC0DE_0000, 32'(i)});
            check(!early, "R12", "ack after response", 64'(early), 64'd0);
            check(fl == er, "R7", "fail flag", 64'(fl), 64'(er));
            if (!we) check(rd == (er ? 64'h0 : rsp_word(exp_a)), er ? "R7" : "R6",
                           "read data", rd, er ? 64'h0 : rsp_word(exp_a));
            exp_st = exp_st | {er, 1'b1};
            check(st_bits == exp_st, er ? "R7" : "R8", "status after forward",
                  64'(st_bits), 64'(exp_st));
        end
        err_next = 1'b0;

        // R10 misaligned access
        f0 = fwd_cnt;
        access(1'b1, 1'b0, 40'h0000_1234_5604, 64'h0, rd, fl, early);
        check(fl && rd == 64'h0 && fwd_cnt == f0, "R10", "misaligned read",
              {rd[62:0], fl}, 64'd1);
        exp_st = exp_st | 2'b11;
        check(st_bits == 2'b11, "R10", "misaligned status", 64'(st_bits), 64'd3);

        // R9 clear only the fail bit
        @(negedge clk); st_clr_we = 1'b1; st_clr_keep = 2'b01;
        @(negedge clk); st_clr_we = 1'b0;
        check(st_bits == 2'b01, "R9", "clear fail bit", 64'(st_bits), 64'd1);
        // R9 status holds without a clear
        repeat (4) @(negedge clk);
        check(st_bits == 2'b01, "R9", "sticky hold", 64'(st_bits), 64'd1);
        // R9 clear everything
        @(negedge clk); st_clr_we = 1'b1; st_clr_keep = 2'b00;
        @(negedge clk); st_clr_we = 1'b0;
        check(st_bits == 2'b00, "R9", "clear all", 64'(st_bits), 64'd0);
        // R9 completion in the clear cycle wins
        access(1'b1, 1'b0, 40'h0000_0000_0004, 64'h0, rd, fl, early);
        check(st_bits == 2'b11, "R9", "set before race", 64'(st_bits), 64'd3);
        @(negedge clk);
        mode_lin = 1'b1; up_we = 1'b0; up_addr = addr_of(1'b1, 32'hF000F); up_req = 1'b1;
        st_clr_we = 1'b1; st_clr_keep = 2'b00;
        @(negedge clk);
        st_clr_we = 1'b0; st_clr_keep = 2'b11;
        check(up_ack == 1'b1, "R12", "local ack next cycle", 64'(up_ack), 64'd1);
        up_req = 1'b0;
        check(st_bits == 2'b01, "R9", "post wins over clear", 64'(st_bits), 64'd1);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule